// File: doc/BRIEF.md
# Fractional-Rate Second-Order CIC Resampler

This block raises the sample rate of one channel by a rational factor L/M, where L/M is at least one. Samples enter on a valid/ready handshake. Results leave on a one-cycle valid strobe. No clock runs at the L-times rate. The block instead advances one virtual high-rate step per clock.

The filter is built in three parts:

- Two first-difference (comb) stages run at the input rate.
- On the virtual L-times sequence, the comb result is placed at every L-th step, with zeros in between.
- Two running-sum (integrator) stages process that virtual sequence.

Every M-th virtual step produces an output. The overall response is ((1 - z^-L)/(1 - z^-1))^2 at the virtual rate, and its DC gain is L. The result is shifted right by ceil(log2 L) and clamped to the output width.

The two factors are programmed minus one. They are sampled on the first clock after reset is released and are frozen until the next reset. If L < M, the block sets a sticky error flag and passes each accepted sample straight through.

Top module: `cic_rs`

## Requirements
- R1: `l_minus1_i` (12 bits) holds L-1 and `m_minus1_i` (9 bits) holds M-1, so L ranges 1..4096 and M ranges 1..512, and an all-zero field means a factor of 1.
- R2: Virtual step n = 0, 1, 2, ... consumes input k = n/L when n is a multiple of L, and emits an output when n is a multiple of M. After K inputs with no further input, exactly (K·L−1)/M + 1 outputs appear.
- R3: The output for virtual step n equals the sum over k of x[k]·h[n−kL]. Here h[j] = j+1 for 0 ≤ j < L, h[j] = 2L−1−j for L ≤ j ≤ 2L−2, and h[j] = 0 elsewhere. That sum is arithmetically shifted right by ceil(log2 L) and saturated to the signed output width.
- R4: With a constant input A and L a power of two, the settled output equals A.
- R5: With L = M = 1, every accepted sample appears unchanged on `out_data_o`, with `out_valid_o` high, in the cycle after acceptance.
- R6: If L < M, `err_o` goes high and stays high until reset. Every accepted sample then appears unchanged (saturated to the output width) in the cycle after acceptance.
- R7: In normal operation, `in_ready_o` is high only at virtual phase 0. When no input is offered at phase 0, the step counter holds and no output is produced, and no filter state is lost.
- R8: While `rst_ni` is low, `in_ready_o`, `out_valid_o` and `err_o` are 0. After release, all filter state starts from zero. The factors are taken on the first clock after release, and later changes to them have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| l_minus1_i | input | 12 | Interpolation factor minus one |
| m_minus1_i | input | 9 | Decimation factor minus one |
| in_valid_i | input | 1 | Input sample offered |
| in_ready_o | output | 1 | Block takes the sample this cycle |
| in_data_i | input | 16 | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 16 | Signed, normalised output sample |
| err_o | output | 1 | Sticky flag for L < M |

## Verification
The in-RTL properties check on every cycle that:

- the phase counters stay within their programmed bounds;
- the error flag never clears on its own;
- a stall at phase 0 freezes the counter and suppresses output;
- in identity mode and in error mode, an accepted sample reappears one cycle later.

The numerical result of the filter, the exact output count for a given number of inputs, DC gain, the extreme factors, and the freezing of the factors after reset can only be shown by the bench. It runs varied L/M scenarios with irregular input gaps and compares each output against a direct convolution model.

// File: rtl/cic_rs_pkg.sv
package cic_rs_pkg;
  localparam int unsigned ORDER = 2;

  function automatic int unsigned ceil_log2_f(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < 31; i++)
      if ((32'd1 << i) < v) r = i + 1;
    return r;
  endfunction
endpackage

// File: rtl/cic_rs_comb.sv
module cic_rs_comb
  import cic_rs_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int CMB_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [CMB_W-1:0] y_o
);
  logic signed [CMB_W-1:0] s [ORDER+1];
  logic signed [CMB_W-1:0] d_q [ORDER];

  assign s[0] = CMB_W'(x_i);

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    assign s[i+1] = s[i] - d_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   d_q[i] <= '0;
      else if (en_i) d_q[i] <= s[i];
    end
  end

  assign y_o = s[ORDER];
endmodule

// File: rtl/cic_rs_integ.sv
module cic_rs_integ
  import cic_rs_pkg::*;
#(
  parameter int ACC_W = 30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] v_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [ACC_W-1:0] s [ORDER+1];
  logic signed [ACC_W-1:0] acc_q [ORDER];

  assign s[0] = v_i;

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    assign s[i+1] = acc_q[i] + s[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q[i] <= '0;
      else if (en_i) acc_q[i] <= s[i+1];
    end
  end

  // new sum visible in the stepping cycle
  assign sum_o = s[ORDER];
endmodule

// File: rtl/cic_rs_norm.sv
module cic_rs_norm #(
  parameter int ACC_W = 30,
  parameter int OUT_W = 16,
  parameter int SH_W  = 4
) (
  input  logic signed [ACC_W-1:0] val_i,
  input  logic        [SH_W-1:0]  shift_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam logic signed [ACC_W-1:0] MAX_V = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_V = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] sh;

  always_comb begin
    sh = val_i >>> shift_i;
    if (sh > MAX_V)      y_o = MAX_V[OUT_W-1:0];
    else if (sh < MIN_V) y_o = MIN_V[OUT_W-1:0];
    else                 y_o = sh[OUT_W-1:0];
  end
endmodule

// File: rtl/cic_rs.sv
module cic_rs
  import cic_rs_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int L_W   = 12,
  parameter int M_W   = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [L_W-1:0]          l_minus1_i,
  input  logic [M_W-1:0]          m_minus1_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic signed [IN_W-1:0]  in_data_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o,
  output logic                    err_o
);
  localparam int CMB_W = IN_W + ORDER;
  localparam int ACC_W = IN_W + L_W + ORDER;
  localparam int SH_W  = $clog2(L_W + 1);

  logic                    loaded_q, err_q;
  logic [L_W-1:0]          l_q, p_q;
  logic [M_W-1:0]          m_q, q_q;
  logic [SH_W-1:0]         shift_q;
  logic                    fire, step, at_zero;
  logic [L_W:0]            l_full;
  logic [M_W:0]            m_full;
  logic signed [CMB_W-1:0] cmb_y;
  logic signed [ACC_W-1:0] v, integ_sum, norm_in;
  logic signed [OUT_W-1:0] norm_y, out_q;
  logic                    out_valid_q;

  assign l_full     = {1'b0, l_minus1_i} + 1'b1;
  assign m_full     = {1'b0, m_minus1_i} + 1'b1;
  assign at_zero    = (p_q == '0);
  assign in_ready_o = loaded_q && (err_q || at_zero);
  assign fire       = in_valid_i && in_ready_o;
  assign step       = loaded_q && !err_q && (!at_zero || in_valid_i);

  // factors captured once per reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      err_q    <= 1'b0;
      l_q      <= '0;
      m_q      <= '0;
      shift_q  <= '0;
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      err_q    <= (int'(l_full) < int'(m_full));
      l_q      <= l_minus1_i;
      m_q      <= m_minus1_i;
      shift_q  <= SH_W'(ceil_log2_f(32'(l_full)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= '0;
      q_q <= '0;
    end else if (step) begin
      p_q <= (p_q == l_q) ? '0 : p_q + 1'b1;
      q_q <= (q_q == m_q) ? '0 : q_q + 1'b1;
    end
  end

  cic_rs_comb #(.IN_W(IN_W), .CMB_W(CMB_W)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(step && at_zero),
    .x_i(in_data_i), .y_o(cmb_y)
  );

  assign v = at_zero ? ACC_W'(cmb_y) : '0;

  cic_rs_integ #(.ACC_W(ACC_W)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(step),
    .v_i(v), .sum_o(integ_sum)
  );

  assign norm_in = err_q ? ACC_W'(in_data_i) : integ_sum;

  cic_rs_norm #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_norm (
    .val_i(norm_in), .shift_i(err_q ? '0 : shift_q), .y_o(norm_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else begin
      out_valid_q <= err_q ? fire : (step && q_q == '0);
      if (err_q ? fire : (step && q_q == '0)) out_q <= norm_y;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_q;
  assign err_o       = err_q;

  // R2
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |-> (p_q <= l_q && q_q <= m_q));

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && !err_q && at_zero && !in_valid_i) |=> (p_q == '0 && !out_valid_o));

  if (OUT_W >= IN_W) begin : g_echo_chk
    // R5
    ident_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loaded_q && !err_q && l_q == '0 && m_q == '0 && fire) |=>
        (out_valid_o && ACC_W'(out_data_o) == ACC_W'($past(in_data_i))));
    // R6
    bypass_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_q && fire) |=>
        (out_valid_o && ACC_W'(out_data_o) == ACC_W'($past(in_data_i))));
  end
endmodule

// File: tb/cic_rs_bench.sv
`timescale 1ns/1ps
module cic_rs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] lm1 = '0;
  logic [8:0]  mm1 = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid, err;
  logic signed [15:0] out_data;

  int xin [64];
  int got [1024];
  int n_got = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cic_rs u_cic_rs (
    .clk_i(clk), .rst_ni(rst_n), .l_minus1_i(lm1), .m_minus1_i(mm1),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .err_o(err)
  );

  always @(negedge clk)
    if (rst_n && out_valid) begin
      if (n_got < 1024) got[n_got] = int'(out_data);
      n_got = n_got + 1;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clog(input int v);
    int s = 0;
    while ((1 << s) < v) s++;
    return s;
  endfunction

  function automatic longint model(input int n, input int L, input int K);
    longint s = 0;
    for (int k = 0; k < K; k++) begin
      int j = n - k * L;
      if (j >= 0 && j <= 2 * L - 2)
        s += longint'(xin[k]) * ((j < L) ? (j + 1) : (2 * L - 1 - j));
    end
    s = s >>> clog(L);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic push(input int d);
    bit rdy;
    in_valid = 1'b1;
    in_data  = 16'(d);
    do begin
      rdy = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!rdy);
    in_valid = 1'b0;
  endtask

  task automatic run(input int L, input int M, input int K, input bit cst, input bit chg);
    int exp_n;
    bit bad;
    @(negedge clk);
    rst_n = 1'b0;
    lm1 = 12'(L - 1);
    mm1 = 9'(M - 1);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!in_ready && !out_valid && !err, "R8", {in_ready, out_valid, err}, 0);
    n_got = 0;
    rst_n = 1'b1;
    for (int k = 0; k < K; k++) begin
      xin[k] = cst ? 1000 : int'($signed(16'($urandom)));
      push(xin[k]);
      if (k == 0 && L > 1 && L >= M)
        chk(in_ready == 1'b0, "R7", in_ready, 0); // not ready off phase 0
      if (k == 0 && chg) begin
        lm1 = '0;  // R8: must be ignored until next reset
        mm1 = '0;
      end
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (L + 8) @(negedge clk);
    bad = (L < M);
    chk(err == bad, bad ? "R6" : "R8", err, bad);
    exp_n = bad ? K : ((K * L - 1) / M + 1);
    chk(n_got == exp_n, L == 4096 ? "R1" : (chg ? "R8" : "R2"), n_got, exp_n);
    for (int i = 0; i < exp_n && i < n_got; i++) begin
      longint e = bad ? longint'(xin[i]) : model(i * M, L, K);
      chk(longint'(got[i]) == e,
          bad ? "R6" : (L == 1 && M == 1 ? "R5" : (chg ? "R8" : "R3")),
          got[i], e);
    end
    if (cst && n_got > 0)
      chk(got[n_got - 1] == 1000, "R4", got[n_got - 1], 1000);
  endtask

  initial begin
    void'($urandom(32'd2024));
    run(1, 1, 40, 1'b0, 1'b0);
    run(8, 3, 30, 1'b1, 1'b0);
    run(5, 3, 40, 1'b0, 1'b0);
    run(16, 5, 20, 1'b0, 1'b0);
    run(7, 7, 30, 1'b0, 1'b0);
    run(3, 4, 20, 1'b0, 1'b0);
    run(6, 4, 20, 1'b0, 1'b1);
    run(4096, 512, 6, 1'b0, 1'b0);
    run(2, 1, 25, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule